// File: doc/BRIEF.md
# Triggered DMA Request Generator

This block produces DMA requests on its own, without a peripheral behind them. One input is picked from a vector of trigger lines. An edge of the chosen kind on that line starts a burst. The burst issues a programmed number of requests. Each request is held until the DMA controller acknowledges it. When the last acknowledge arrives, the generator goes back to waiting for the next trigger.

A trigger that arrives while the burst still has requests to issue beyond the pending one is counted as an overrun. It raises a sticky flag and does not disturb the burst in progress. Software clears the flag by writing a one to a clear strobe. The interrupt output is the flag gated by an interrupt enable.

Configuration is a single write strobe that carries every field at once: trigger select, enable, edge mode, burst count and interrupt enable. The burst count field is taken only while the generator is disabled.

The sequencer has three states:
- `ST_IDLE` waits for a trigger.
- `ST_BURST` has a request pending and at least one more to follow.
- `ST_FINAL` has the last request of the burst pending.

Its transitions are:
- trigger in idle: to `ST_BURST`, or to `ST_FINAL` when the count is zero.
- acknowledge in burst: stay in `ST_BURST` and advance, or move to `ST_FINAL` on the second-to-last acknowledge.
- acknowledge in final: back to `ST_IDLE`.
- disable: to `ST_IDLE` from any state.

Top module: `trig_dreq_gen`

## Requirements
- R1: After reset the generator is disabled with edge mode 0, no request is pending, and `dreq_o`, `ovr_flag_o` and `irq_o` are all low.
- R2: Only the trigger line indexed by the stored select value can start a burst; edges on any other line have no effect.
- R3: The 2-bit edge mode decides what counts as a trigger event: 0 is none, 1 is a low-to-high change, 2 is a high-to-low change, 3 is either change. Edges are judged against the line's value in the previous clock cycle.
- R4: With a stored burst count G (0 to 31), each trigger taken in idle yields exactly G+1 acknowledged requests. After that, `dreq_o` stays low until the next trigger.
- R5: `dreq_o` rises in the cycle after the edge is seen and stays high until `dack_i` is sampled high. If requests remain, it stays high in the following cycle for the next request. It drops in the cycle after the last acknowledge.
- R6: A trigger event taken while the number of acknowledged requests in the running burst is below G sets `ovr_flag_o`. A trigger during the final pending request sets nothing. A set in the same cycle as a clear wins.
- R7: An overrun trigger neither restarts nor lengthens the running burst.
- R8: A cycle with `ovr_clr_i` high and no concurrent overrun clears `ovr_flag_o` on the next edge.
- R9: `irq_o` is high exactly when `ovr_flag_o` is high and the stored interrupt enable is 1.
- R10: A configuration write while the stored enable is 1 leaves the burst count unchanged. The other fields are still taken.
- R11: A write that clears enable ends any burst. `dreq_o` is low from the next cycle, and the progress count is discarded, so no leftover requests appear after re-enabling.
- R12: While disabled, trigger edges are ignored and start nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_in | input | NUM_TRIG | Trigger lines, synchronous to clk |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | SEL_W | Trigger line index |
| cfg_en | input | 1 | Generator enable |
| cfg_mode | input | 2 | Edge mode (0 none, 1 rise, 2 fall, 3 both) |
| cfg_cnt | input | CNT_W | Burst count G (requests = G+1), taken only while disabled |
| cfg_ie | input | 1 | Overrun interrupt enable |
| ovr_clr_i | input | 1 | Write-1 clear of the overrun flag |
| dreq_o | output | 1 | Generated DMA request |
| dack_i | input | 1 | DMA acknowledge for the pending request |
| ovr_flag_o | output | 1 | Sticky overrun flag |
| irq_o | output | 1 | Overrun interrupt |

## Verification
The properties assume that the trigger lines and the acknowledge are synchronous to the clock and change only between edges. They also assume the acknowledge means something only while a request is pending. The bench meets this by changing every input shortly after the falling edge. Its acknowledge driver raises `dack_i` only while `dreq_o` is high, after a programmable wait. Configuration writes are single-cycle strobes. Any burst count sent while the generator is enabled is a deliberate probe of the write lock.

// File: rtl/trig_dreq_pkg.sv
package trig_dreq_pkg;

    // Edge mode codes, values fixed by the configuration interface
    typedef enum logic [1:0] {
        EDGE_NONE = 2'd0,
        EDGE_RISE = 2'd1,
        EDGE_FALL = 2'd2,
        EDGE_BOTH = 2'd3
    } edge_mode_e;

    // Burst sequencer states
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BURST = 2'd1,
        ST_FINAL = 2'd2
    } gen_state_e;

    function automatic logic edge_match(edge_mode_e mode, logic cur, logic prev);
        logic hit;
        unique case (mode)
            EDGE_NONE: hit = 1'b0;
            EDGE_RISE: hit = cur & ~prev;
            EDGE_FALL: hit = ~cur & prev;
            EDGE_BOTH: hit = cur ^ prev;
            default:   hit = 1'b0;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/trig_cfg_regs.sv
module trig_cfg_regs
    import trig_dreq_pkg::*;
#(
    parameter int SEL_W = 5,
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_stb,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic             wr_en,
    input  logic [1:0]       wr_mode,
    input  logic [CNT_W-1:0] wr_cnt,
    input  logic             wr_ie,
    output logic [SEL_W-1:0] sel_q,
    output logic             en_q,
    output edge_mode_e       mode_q,
    output logic [CNT_W-1:0] cnt_q,
    output logic             ie_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q  <= '0;
            en_q   <= 1'b0;
            mode_q <= EDGE_NONE;
            cnt_q  <= '0;
            ie_q   <= 1'b0;
        end else if (wr_stb) begin
            sel_q  <= wr_sel;
            en_q   <= wr_en;
            mode_q <= edge_mode_e'(wr_mode);
            ie_q   <= wr_ie;
            // burst length is locked while the generator runs
            if (!en_q) begin
                cnt_q <= wr_cnt;
            end
        end
    end

endmodule

// File: rtl/trig_edge_det.sv
module trig_edge_det
    import trig_dreq_pkg::*;
#(
    parameter int NUM_TRIG = 32,
    parameter int SEL_W    = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_TRIG-1:0] lines,
    input  logic [SEL_W-1:0]    sel,
    input  edge_mode_e          mode,
    input  logic                arm,
    output logic                hit
);

    // Whole vector is delayed, so switching the select never fakes an edge
    logic [NUM_TRIG-1:0] lines_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lines_q <= '0;
        end else begin
            lines_q <= lines;
        end
    end

    always_comb begin
        hit = arm & edge_match(mode, lines[sel], lines_q[sel]);
    end

endmodule

// File: rtl/trig_burst_fsm.sv
module trig_burst_fsm
    import trig_dreq_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             hit,
    input  logic             ack,
    input  logic [CNT_W-1:0] last_idx,
    output logic             req,
    output logic             ovr_evt,
    output logic             busy,
    output logic [CNT_W-1:0] done_cnt
);

    gen_state_e       st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] cnt_inc;

    always_comb begin
        cnt_inc = CNT_W'(cnt_q + 1'b1);
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // transitions
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        if (!en) begin
            st_d  = ST_IDLE;
            cnt_d = '0;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    if (hit) begin
                        cnt_d = '0;
                        st_d  = (last_idx == '0) ? ST_FINAL : ST_BURST;
                    end
                end
                ST_BURST: begin
                    if (ack) begin
                        cnt_d = cnt_inc;
                        if (cnt_inc == last_idx) begin
                            st_d = ST_FINAL;
                        end
                    end
                end
                ST_FINAL: begin
                    if (ack) begin
                        cnt_d = '0;
                        st_d  = ST_IDLE;
                    end
                end
                default: begin
                    st_d  = ST_IDLE;
                    cnt_d = '0;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        busy     = (st_q != ST_IDLE);
        req      = en & busy;
        ovr_evt  = en & hit & (st_q == ST_BURST);
        done_cnt = cnt_q;
    end

endmodule

// File: rtl/trig_ovr_flag.sv
module trig_ovr_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    input  logic ie,
    output logic flag,
    output logic irq
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (set) begin
            flag <= 1'b1;
        end else if (clr) begin
            flag <= 1'b0;
        end
    end

    always_comb begin
        irq = flag & ie;
    end

endmodule

// File: rtl/trig_dreq_gen.sv
module trig_dreq_gen
    import trig_dreq_pkg::*;
#(
    parameter int   NUM_TRIG = 32,
    parameter int   CNT_W    = 5,
    localparam int  SEL_W    = (NUM_TRIG > 1) ? $clog2(NUM_TRIG) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_TRIG-1:0] trig_in,
    input  logic                cfg_we,
    input  logic [SEL_W-1:0]    cfg_sel,
    input  logic                cfg_en,
    input  logic [1:0]          cfg_mode,
    input  logic [CNT_W-1:0]    cfg_cnt,
    input  logic                cfg_ie,
    input  logic                ovr_clr_i,
    output logic                dreq_o,
    input  logic                dack_i,
    output logic                ovr_flag_o,
    output logic                irq_o
);

    logic [SEL_W-1:0] sel_q;
    logic             en_q;
    edge_mode_e       mode_q;
    logic [CNT_W-1:0] gen_cnt;
    logic             ie_q;
    logic             trig_hit;
    logic             ovr_evt;
    logic             busy;
    logic [CNT_W-1:0] burst_cnt;

    trig_cfg_regs #(.SEL_W(SEL_W), .CNT_W(CNT_W)) cfg_u (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_stb  (cfg_we),
        .wr_sel  (cfg_sel),
        .wr_en   (cfg_en),
        .wr_mode (cfg_mode),
        .wr_cnt  (cfg_cnt),
        .wr_ie   (cfg_ie),
        .sel_q   (sel_q),
        .en_q    (en_q),
        .mode_q  (mode_q),
        .cnt_q   (gen_cnt),
        .ie_q    (ie_q)
    );

    trig_edge_det #(.NUM_TRIG(NUM_TRIG), .SEL_W(SEL_W)) edge_u (
        .clk   (clk),
        .rst_n (rst_n),
        .lines (trig_in),
        .sel   (sel_q),
        .mode  (mode_q),
        .arm   (en_q),
        .hit   (trig_hit)
    );

    trig_burst_fsm #(.CNT_W(CNT_W)) fsm_u (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en_q),
        .hit      (trig_hit),
        .ack      (dack_i),
        .last_idx (gen_cnt),
        .req      (dreq_o),
        .ovr_evt  (ovr_evt),
        .busy     (busy),
        .done_cnt (burst_cnt)
    );

    trig_ovr_flag flag_u (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (ovr_evt),
        .clr   (ovr_clr_i),
        .ie    (ie_q),
        .flag  (ovr_flag_o),
        .irq   (irq_o)
    );

endmodule

// File: rtl/trig_dreq_gen_chk.sv
module trig_dreq_gen_chk #(
    parameter int CNT_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_we,
    input logic             cfg_en,
    input logic             ovr_clr_i,
    input logic             dreq_o,
    input logic             dack_i,
    input logic             ovr_flag_o,
    input logic             busy,
    input logic [CNT_W-1:0] burst_cnt,
    input logic [CNT_W-1:0] gen_cnt
);

    // R5: an unacknowledged request stays up unless configuration changes
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (dreq_o && !dack_i && !cfg_we) |=> dreq_o);

    // R11: a disabling write removes the request on the next cycle
    a_r11_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !cfg_en) |=> !dreq_o);

    // R8: clearing with no request pending always empties the flag
    a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_clr_i && !dreq_o) |=> !ovr_flag_o);

    // R6: the flag can only rise out of a cycle with a request pending
    a_r6_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr_flag_o) |-> $past(dreq_o));

    // R4: progress within a burst never passes the programmed count
    a_r4_bound: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (burst_cnt <= gen_cnt));

endmodule

bind trig_dreq_gen trig_dreq_gen_chk #(.CNT_W(CNT_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_en     (cfg_en),
    .ovr_clr_i  (ovr_clr_i),
    .dreq_o     (dreq_o),
    .dack_i     (dack_i),
    .ovr_flag_o (ovr_flag_o),
    .busy       (busy),
    .burst_cnt  (burst_cnt),
    .gen_cnt    (gen_cnt)
);

// File: tb/trig_dreq_gen_tb_top.sv
`timescale 1ns/1ps
module trig_dreq_gen_tb_top;
    localparam int NT = 32;
    localparam int CW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NT-1:0] trig_in = '0;
    logic          cfg_we = 1'b0;
    logic [4:0]    cfg_sel = '0;
    logic          cfg_en = 1'b0;
    logic [1:0]    cfg_mode = '0;
    logic [CW-1:0] cfg_cnt = '0;
    logic          cfg_ie = 1'b0;
    logic          ovr_clr_i = 1'b0;
    logic          dreq_o;
    logic          dack_i = 1'b0;
    logic          ovr_flag_o;
    logic          irq_o;

    int errors = 0;
    int checks = 0;
    int hs_cnt = 0;
    bit ack_on = 1'b1;
    int ack_lat = 0;
    int wcnt = 0;
    bit done = 1'b0;

    // behavioural reference state
    int m_en, m_sel, m_mode, m_g, m_ie, m_busy, m_n, m_ovr;
    logic [NT-1:0] m_prev;

    trig_dreq_gen #(.NUM_TRIG(NT), .CNT_W(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .cfg_we(cfg_we),
        .cfg_sel(cfg_sel), .cfg_en(cfg_en), .cfg_mode(cfg_mode),
        .cfg_cnt(cfg_cnt), .cfg_ie(cfg_ie), .ovr_clr_i(ovr_clr_i),
        .dreq_o(dreq_o), .dack_i(dack_i), .ovr_flag_o(ovr_flag_o), .irq_o(irq_o)
    );

    always #4 clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // reference model, advanced once per rising edge from pre-edge values
    always @(posedge clk) begin
        if (!rst_n) begin
            m_en = 0; m_sel = 0; m_mode = 0; m_g = 0; m_ie = 0;
            m_busy = 0; m_n = 0; m_ovr = 0; m_prev = '0;
        end else begin
            int cur, prv, ev, oset, nb, nn;
            cur = int'(trig_in[m_sel]);
            prv = int'(m_prev[m_sel]);
            ev = 0;
            if (m_en != 0) begin
                if (m_mode == 1 && cur == 1 && prv == 0) ev = 1;
                if (m_mode == 2 && cur == 0 && prv == 1) ev = 1;
                if (m_mode == 3 && cur != prv) ev = 1;
            end
            oset = (m_busy != 0 && ev != 0 && m_n < m_g) ? 1 : 0;
            nb = m_busy; nn = m_n;
            if (m_en == 0) begin
                nb = 0; nn = 0;
            end else if (m_busy == 0) begin
                nb = ev; nn = 0;
            end else if (dack_i) begin
                if (m_n == m_g) begin nb = 0; nn = 0; end
                else nn = m_n + 1;
            end
            if (oset != 0) m_ovr = 1;
            else if (ovr_clr_i) m_ovr = 0;
            if (cfg_we) begin
                if (m_en == 0) m_g = int'(cfg_cnt);
                m_en = int'(cfg_en); m_sel = int'(cfg_sel);
                m_mode = int'(cfg_mode); m_ie = int'(cfg_ie);
            end
            m_busy = nb; m_n = nn;
            m_prev = trig_in;
            if (dreq_o && dack_i) hs_cnt++;
        end
    end

    // cycle compare against the reference
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R5 request vs model", int'(dreq_o), (m_en != 0 && m_busy != 0) ? 1 : 0);
            chk("R6 flag vs model", int'(ovr_flag_o), m_ovr);
            chk("R9 irq vs model", int'(irq_o), (m_ovr != 0 && m_ie != 0) ? 1 : 0);
        end
    end

    // acknowledge driver: answers a pending request after ack_lat waiting cycles
    always @(negedge clk) begin
        #1;
        if (dreq_o && ack_on) begin
            if (wcnt >= ack_lat) begin dack_i = 1'b1; wcnt = 0; end
            else begin dack_i = 1'b0; wcnt++; end
        end else begin
            dack_i = 1'b0; wcnt = 0;
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cfg_write(input int sel, input bit en, input int mode, input int cnt, input bit ie);
        @(negedge clk); #1;
        cfg_we = 1'b1; cfg_sel = 5'(sel); cfg_en = en;
        cfg_mode = 2'(mode); cfg_cnt = CW'(cnt); cfg_ie = ie;
        @(negedge clk); #1;
        cfg_we = 1'b0;
    endtask

    task automatic set_trig(input int idx, input bit v);
        @(negedge clk); #1;
        trig_in[idx] = v;
    endtask

    task automatic clear_flag();
        @(negedge clk); #1;
        ovr_clr_i = 1'b1;
        @(negedge clk); #1;
        ovr_clr_i = 1'b0;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++; checks++;
            $display("FAIL watchdog actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

    initial begin
        int h0;
        wait_cyc(4);
        @(negedge clk); #1; rst_n = 1'b1;
        wait_cyc(2);
        chk("R1 reset request", int'(dreq_o), 0);
        chk("R1 reset flag", int'(ovr_flag_o), 0);
        chk("R1 reset irq", int'(irq_o), 0);

        // R12: disabled generator ignores edges
        h0 = hs_cnt;
        set_trig(3, 1); wait_cyc(3); set_trig(3, 0); wait_cyc(3);
        chk("R12 edge while disabled", hs_cnt - h0, 0);

        // R2: select
        cfg_write(3, 1, 1, 0, 0);
        h0 = hs_cnt;
        set_trig(7, 1); wait_cyc(5); set_trig(7, 0); wait_cyc(5);
        chk("R2 unselected line", hs_cnt - h0, 0);
        set_trig(3, 1); wait_cyc(6);
        chk("R2 selected line", hs_cnt - h0, 1);
        set_trig(3, 0); wait_cyc(3);

        // R3: edge modes
        cfg_write(3, 1, 2, 0, 0);
        h0 = hs_cnt;
        set_trig(3, 1); wait_cyc(5);
        chk("R3 rise under fall mode", hs_cnt - h0, 0);
        set_trig(3, 0); wait_cyc(5);
        chk("R3 fall mode", hs_cnt - h0, 1);
        cfg_write(3, 1, 3, 0, 0);
        h0 = hs_cnt;
        set_trig(3, 1); wait_cyc(5); set_trig(3, 0); wait_cyc(5);
        chk("R3 both edges", hs_cnt - h0, 2);
        cfg_write(3, 1, 0, 0, 0);
        h0 = hs_cnt;
        set_trig(3, 1); wait_cyc(5); set_trig(3, 0); wait_cyc(5);
        chk("R3 mode zero", hs_cnt - h0, 0);

        // R10: count locked while enabled
        cfg_write(3, 1, 1, 5, 0);
        h0 = hs_cnt;
        set_trig(3, 1); wait_cyc(15); set_trig(3, 0); wait_cyc(2);
        chk("R10 locked count", hs_cnt - h0, 1);

        // R4: burst lengths
        cfg_write(3, 0, 1, 3, 0);
        cfg_write(3, 1, 1, 3, 0);
        ack_lat = 1;
        h0 = hs_cnt;
        set_trig(3, 1); wait_cyc(20);
        chk("R4 four requests", hs_cnt - h0, 4);
        chk("R4 idle after burst", int'(dreq_o), 0);
        set_trig(3, 0);
        cfg_write(3, 0, 1, 31, 0);
        cfg_write(3, 1, 1, 31, 0);
        ack_lat = 0;
        h0 = hs_cnt;
        set_trig(3, 1); wait_cyc(40);
        chk("R4 max count", hs_cnt - h0, 32);
        set_trig(3, 0);

        // R5: request held without acknowledge
        cfg_write(3, 0, 1, 0, 1);
        cfg_write(3, 1, 1, 0, 1);
        ack_on = 1'b0;
        h0 = hs_cnt;
        set_trig(3, 1); wait_cyc(6);
        chk("R5 held without ack", int'(dreq_o), 1);
        ack_on = 1'b1;
        wait_cyc(3);
        chk("R5 drop after ack", int'(dreq_o), 0);
        chk("R5 one handshake", hs_cnt - h0, 1);
        set_trig(3, 0);

        // R6 R7 R9: overrun mid-burst
        cfg_write(3, 0, 1, 4, 1);
        cfg_write(3, 1, 1, 4, 1);
        ack_lat = 3;
        h0 = hs_cnt;
        set_trig(3, 1); wait_cyc(2); set_trig(3, 0); wait_cyc(3); set_trig(3, 1);
        wait_cyc(40);
        chk("R6 overrun flag", int'(ovr_flag_o), 1);
        chk("R7 burst unchanged", hs_cnt - h0, 5);
        chk("R9 irq enabled", int'(irq_o), 1);
        clear_flag(); wait_cyc(1);
        chk("R8 cleared", int'(ovr_flag_o), 0);
        chk("R9 irq after clear", int'(irq_o), 0);
        set_trig(3, 0);

        // R6: trigger during final request is not an overrun
        cfg_write(3, 0, 1, 1, 0);
        cfg_write(3, 1, 1, 1, 0);
        ack_lat = 8;
        h0 = hs_cnt;
        set_trig(3, 1); wait_cyc(3); set_trig(3, 0); wait_cyc(8); set_trig(3, 1);
        wait_cyc(20);
        chk("R6 no overrun on final", int'(ovr_flag_o), 0);
        chk("R4 two requests", hs_cnt - h0, 2);
        set_trig(3, 0);

        // R9: overrun with interrupt disabled
        cfg_write(3, 0, 3, 4, 0);
        cfg_write(3, 1, 3, 4, 0);
        ack_lat = 3;
        set_trig(3, 1); wait_cyc(4); set_trig(3, 0);
        wait_cyc(30);
        chk("R9 flag set", int'(ovr_flag_o), 1);
        chk("R9 irq masked", int'(irq_o), 0);
        clear_flag();

        // R11: disable aborts
        cfg_write(3, 0, 1, 6, 0);
        cfg_write(3, 1, 1, 6, 0);
        h0 = hs_cnt;
        set_trig(3, 1); wait_cyc(6);
        cfg_write(3, 0, 1, 6, 0);
        chk("R11 request gone", int'(dreq_o), 0);
        chk("R11 burst cut", (hs_cnt - h0 < 7) ? 1 : 0, 1);
        h0 = hs_cnt;
        cfg_write(3, 1, 1, 6, 0);
        wait_cyc(12);
        chk("R11 no leftover", hs_cnt - h0, 0);
        chk("R11 idle after enable", int'(dreq_o), 0);

        wait_cyc(2);
        done = 1'b1;
        summary();
        $finish;
    end
endmodule